// File: doc/BRIEF.md
# Domain Clock-Idle and Rail-Gating Sequencer

This block manages power saving for six on-chip functional domains: the processor core, the cache, the DMA engine, the clock generator, the peripheral group and the external memory port. Each domain offers two levels of saving. The first is a clock stop, which keeps the supply up and lets the domain resume in the next cycle. The second is a supply-rail shut-off, which removes leakage but needs a programmed number of wake cycles before the domain can be used again. Software controls both levels by writing a clock-idle register and a rail-enable register. It can also read back those registers, the per-domain ready flags and the per-domain wake counts.

Each domain has a small sequencer that enforces a safe order. On power-down the clock stops first and the rail opens one cycle later. On power-up the rail closes first, and the clock and ready flag return only after the wake count has run out. The core rail is locked on, and an attempt to clear it is recorded in a sticky flag. The clock generator cannot stop while any other domain still has a running clock. A 2-bit standby strap selects which domains come out of reset powered, so domains that are not needed stay off through boot.

Top module: `pwr_domain_ctrl`

## Requirements
- R1: Bit positions in every per-domain vector are fixed: bit0 core, bit1 cache, bit2 DMA, bit3 clock generator, bit4 peripherals, bit5 external memory port.
- R2: At reset the rail register and `dom_rail_en`/`dom_ready`/`dom_clk_en` take the profile that `standby_mode` selects: 0 gives 6'h3F, 1 gives 6'h09, 2 gives 6'h0B and 3 gives 6'h29. The idle register resets to the complement of the profile, the error flag resets to 0, and every wake count resets to 4.
- R3: The register map is: address 0 is clock idle (read/write, 1 = stop clock), address 1 is rail enable (read/write, 1 = powered), address 2 is the ready flags (read-only), address 3 is the error flag (bit0), and address 8+d is the wake count of domain d. All other addresses read as 0.
- R4: If the idle bit of a ready domain changes on a write edge, `dom_clk_en` follows right after that edge. Rail and ready do not change.
- R5: If a rail bit is cleared on write edge k, that domain's clock and ready drop after edge k+1 and its rail drops after edge k+2.
- R6: If a rail bit is set on write edge k for an unpowered domain, its rail rises after edge k+1. Its ready and clock rise exactly L cycles later, where L is its wake count. A wake count written as 0 is stored, and acts, as 1.
- R7: A rail write with bit0 at 0 leaves the core rail on and sets the sticky `core_rail_err`. The other bits of that write are applied.
- R8: Writing address 3 with bit0 at 1 clears the error flag. A write there with bit0 at 0 leaves it unchanged.
- R9: A set clock-generator idle bit holds its clock running while any other domain's clock runs. The clock stops as soon as no other clock runs. The idle register reads back the written value.
- R10: No domain has its clock enabled or ready flag set while its rail is off.
- R11: Each domain's wake count is stored and read back independently of the others.
- R12: A domain powered up with its idle bit set becomes ready with its clock still stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| standby_mode | input | 2 | Boot profile strap, stable while reset is asserted |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| dom_clk_en | output | 6 | Per-domain clock enable |
| dom_rail_en | output | 6 | Per-domain supply rail enable |
| dom_ready | output | 6 | Per-domain usable flag |
| core_rail_err | output | 1 | Sticky flag for a refused core rail-off write |

## Verification
The assertions assume that `standby_mode` is stable whenever reset is asserted, and that reset is held for at least one clock edge, so the boot profile is loaded cleanly. They also assume that no register write arrives during the two-cycle reset release, because a write there is dropped while the error-flag properties expect it to act. The stimulus meets these conditions. It sets the strap before it drops reset, holds reset for three edges, and issues its first write only after the release has finished. It drives every write half a cycle away from the sampling edge.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int NUM_DOM    = 6;
  localparam int DOM_CORE   = 0;
  localparam int DOM_CACHE  = 1;
  localparam int DOM_DMA    = 2;
  localparam int DOM_CLKGEN = 3;
  localparam int DOM_PERIPH = 4;
  localparam int DOM_XMEM   = 5;

  localparam int ADDR_IDLE  = 0;
  localparam int ADDR_RAIL  = 1;
  localparam int ADDR_READY = 2;
  localparam int ADDR_ERR   = 3;
  localparam int ADDR_LAT0  = 8;

  typedef enum logic [1:0] {
    SEQ_OFF   = 2'd0,
    SEQ_WAKE  = 2'd1,
    SEQ_ON    = 2'd2,
    SEQ_DRAIN = 2'd3
  } seq_state_e;

  // Boot profile: which domains are powered when reset ends
  function automatic logic [NUM_DOM-1:0] boot_profile(input logic [1:0] mode);
    logic [NUM_DOM-1:0] p;
    case (mode)
      2'd0:    p = 6'h3F;  // everything on
      2'd1:    p = 6'h09;  // core and clock generator only
      2'd2:    p = 6'h0B;  // plus cache
      default: p = 6'h29;  // core, clock generator, external memory
    endcase
    return p;
  endfunction
endpackage

// File: rtl/pdc_rst_sync.sv
module pdc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/pdc_regfile.sv
module pdc_regfile
  import pdc_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int LAT_W   = 8,
  parameter int DEF_LAT = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    standby_mode,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [DATA_W-1:0]             rd_data,
  input  logic [NUM_DOM-1:0]            dom_ready,
  output logic [NUM_DOM-1:0]            idle_q,
  output logic [NUM_DOM-1:0]            rail_q,
  output logic [NUM_DOM-1:0][LAT_W-1:0] lat_q,
  output logic                          err_q
);
  localparam logic [ADDR_W-1:0] A_IDLE  = ADDR_W'(ADDR_IDLE);
  localparam logic [ADDR_W-1:0] A_RAIL  = ADDR_W'(ADDR_RAIL);
  localparam logic [ADDR_W-1:0] A_READY = ADDR_W'(ADDR_READY);
  localparam logic [ADDR_W-1:0] A_ERR   = ADDR_W'(ADDR_ERR);

  logic [NUM_DOM-1:0]            idle_d, rail_d;
  logic [NUM_DOM-1:0][LAT_W-1:0] lat_d;
  logic                          err_d;
  logic [NUM_DOM-1:0]            boot_mask;

  assign boot_mask = boot_profile(standby_mode);

  // next-state decode
  always_comb begin
    idle_d = idle_q;
    rail_d = rail_q;
    lat_d  = lat_q;
    err_d  = err_q;
    if (wr_en) begin
      case (wr_addr)
        A_IDLE: idle_d = wr_data[NUM_DOM-1:0];
        A_RAIL: begin
          rail_d = wr_data[NUM_DOM-1:0];
          if (!wr_data[DOM_CORE]) begin
            rail_d[DOM_CORE] = 1'b1;
            err_d            = 1'b1;
          end
        end
        A_ERR: if (wr_data[0]) err_d = 1'b0;
        default: ;
      endcase
      for (int i = 0; i < NUM_DOM; i++) begin
        if (wr_addr == ADDR_W'(ADDR_LAT0 + i)) begin
          lat_d[i] = (wr_data[LAT_W-1:0] == '0) ? LAT_W'(1) : wr_data[LAT_W-1:0];
        end
      end
    end
  end

  // registers, enabled only by a write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= ~boot_mask;
      rail_q <= boot_mask;
      lat_q  <= {NUM_DOM{LAT_W'(DEF_LAT)}};
      err_q  <= 1'b0;
    end else if (wr_en) begin
      idle_q <= idle_d;
      rail_q <= rail_d;
      lat_q  <= lat_d;
      err_q  <= err_d;
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_IDLE:  rd_data[NUM_DOM-1:0] = idle_q;
      A_RAIL:  rd_data[NUM_DOM-1:0] = rail_q;
      A_READY: rd_data[NUM_DOM-1:0] = dom_ready;
      A_ERR:   rd_data[0]           = err_q;
      default: ;
    endcase
    for (int i = 0; i < NUM_DOM; i++) begin
      if (rd_addr == ADDR_W'(ADDR_LAT0 + i)) rd_data[LAT_W-1:0] = lat_q[i];
    end
  end
endmodule

// File: rtl/pdc_dom_seq.sv
module pdc_dom_seq
  import pdc_pkg::*;
#(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_on,
  input  logic             rail_req,
  input  logic             idle_req,
  input  logic [LAT_W-1:0] wake_lat,
  output logic             clk_en,
  output logic             rail_en,
  output logic             ready
);
  seq_state_e       state_q, state_d;
  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ld;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_ld  = 1'b0;
    case (state_q)
      SEQ_OFF: begin
        if (rail_req) begin
          state_d = SEQ_WAKE;
          cnt_d   = wake_lat;
          cnt_ld  = 1'b1;
        end
      end
      SEQ_WAKE: begin
        if (!rail_req)                 state_d = SEQ_OFF;
        else if (cnt_q <= LAT_W'(1))   state_d = SEQ_ON;
        else begin
          cnt_d  = cnt_q - LAT_W'(1);
          cnt_ld = 1'b1;
        end
      end
      SEQ_ON:    if (!rail_req) state_d = SEQ_DRAIN;
      default:   state_d = SEQ_OFF;  // drain: clock already stopped
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= boot_on ? SEQ_ON : SEQ_OFF;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  assign rail_en = (state_q != SEQ_OFF);
  assign ready   = (state_q == SEQ_ON);
  assign clk_en  = ready && !idle_req;
endmodule

// File: rtl/pwr_domain_ctrl.sv
module pwr_domain_ctrl
  import pdc_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter int LAT_W        = 8,
  parameter int DEF_WAKE_LAT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         standby_mode,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic [NUM_DOM-1:0] dom_clk_en,
  output logic [NUM_DOM-1:0] dom_rail_en,
  output logic [NUM_DOM-1:0] dom_ready,
  output logic               core_rail_err
);
  localparam logic [NUM_DOM-1:0] CLKGEN_BIT = NUM_DOM'(1) << DOM_CLKGEN;

  logic                          rst_n_int;
  logic [NUM_DOM-1:0]            idle_q, rail_q, idle_eff, boot_mask;
  logic [NUM_DOM-1:0][LAT_W-1:0] lat_q;
  logic                          others_on;

  pdc_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pdc_regfile #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .LAT_W (LAT_W), .DEF_LAT (DEF_WAKE_LAT)
  ) regs_i (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .standby_mode (standby_mode),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .dom_ready    (dom_ready),
    .idle_q       (idle_q),
    .rail_q       (rail_q),
    .lat_q        (lat_q),
    .err_q        (core_rail_err)
  );

  assign boot_mask = boot_profile(standby_mode);

  // a non-generator clock is running when its domain is ready and not idled
  assign others_on = |(dom_ready & ~idle_q & ~CLKGEN_BIT);

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    if (d == DOM_CLKGEN) begin : g_gen
      assign idle_eff[d] = idle_q[d] & ~others_on;  // held pending
    end else begin : g_plain
      assign idle_eff[d] = idle_q[d];
    end

    pdc_dom_seq #(.LAT_W(LAT_W)) seq_i (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .boot_on  (boot_mask[d]),
      .rail_req (rail_q[d]),
      .idle_req (idle_eff[d]),
      .wake_lat (lat_q[d]),
      .clk_en   (dom_clk_en[d]),
      .rail_en  (dom_rail_en[d]),
      .ready    (dom_ready[d])
    );
  end
endmodule

// File: rtl/pwr_domain_ctrl_chk.sv
module pwr_domain_ctrl_chk
  import pdc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic               wr_bit0,
  input logic [NUM_DOM-1:0] dom_clk_en,
  input logic [NUM_DOM-1:0] dom_rail_en,
  input logic [NUM_DOM-1:0] dom_ready,
  input logic               core_rail_err
);
  localparam logic [NUM_DOM-1:0] GEN_MASK = NUM_DOM'(1) << DOM_CLKGEN;

  assert_clk_needs_rail_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_clk_en & ~dom_rail_en) == '0);

  assert_ready_needs_rail_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_ready & ~dom_rail_en) == '0);

  assert_core_rail_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dom_rail_en[DOM_CORE]);

  assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(ADDR_RAIL) && !wr_bit0) |=> core_rail_err);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rail_err && !(wr_en && wr_addr == ADDR_W'(ADDR_ERR) && wr_bit0)) |=> core_rail_err);

  assert_gen_clock_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(dom_clk_en & ~GEN_MASK)) && dom_ready[DOM_CLKGEN]) |-> dom_clk_en[DOM_CLKGEN]);

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
    assert_clock_stops_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dom_rail_en[g]) |-> !$past(dom_clk_en[g]));

    assert_rail_before_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dom_ready[g]) |-> $past(dom_rail_en[g]));
  end
endmodule

bind pwr_domain_ctrl pwr_domain_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .wr_bit0       (wr_data[0]),
  .dom_clk_en    (dom_clk_en),
  .dom_rail_en   (dom_rail_en),
  .dom_ready     (dom_ready),
  .core_rail_err (core_rail_err)
);

// File: tb/pwr_domain_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_domain_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] standby_mode = 2'd0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [5:0] dom_clk_en, dom_rail_en, dom_ready;
  logic       core_rail_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_domain_ctrl dut_i (
    .clk (clk), .rst_n (rst_n), .standby_mode (standby_mode),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .rd_addr (rd_addr), .rd_data (rd_data),
    .dom_clk_en (dom_clk_en), .dom_rail_en (dom_rail_en),
    .dom_ready (dom_ready), .core_rail_err (core_rail_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_profile(input int m);
    case (m)
      0: return 6'h3F;
      1: return 6'h09;
      2: return 6'h0B;
      default: return 6'h29;
    endcase
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic do_reset(input int m);
    @(negedge clk);
    rst_n = 1'b0;
    standby_mode = 2'(m);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic t_reset_profiles();
    logic [7:0] v;
    for (int m = 3; m >= 0; m--) begin
      do_reset(m);
      chk($sformatf("R2 rail mode%0d", m), dom_rail_en, exp_profile(m));
      chk($sformatf("R2 ready mode%0d", m), dom_ready, exp_profile(m));
      chk($sformatf("R2 clk mode%0d", m), dom_clk_en, exp_profile(m));
      rd(4'd0, v); chk("R2 idle reset", v, {2'b00, ~exp_profile(m)});
      rd(4'd1, v); chk("R2 rail reg reset", v, {2'b00, exp_profile(m)});
      rd(4'd2, v); chk("R3 ready readback", v, {2'b00, exp_profile(m)});
    end
    chk("R2 err reset", core_rail_err, 0);
    rd(4'd10, v); chk("R2 wake count reset", v, 4);
    rd(4'd5, v);  chk("R3 unmapped reads zero", v, 0);
  endtask

  task automatic t_idle();
    logic [7:0] v;
    wr(4'd0, 8'h02);
    chk("R4 R1 cache clock idled", dom_clk_en, 6'h3D);
    chk("R4 rail kept", dom_rail_en, 6'h3F);
    chk("R4 ready kept", dom_ready, 6'h3F);
    rd(4'd0, v); chk("R3 idle readback", v, 8'h02);
    wr(4'd0, 8'h00);
    chk("R4 cache clock resumed", dom_clk_en, 6'h3F);
  endtask

  task automatic t_power_down();
    wr(4'd1, 8'h3D);
    chk("R5 clock still on at write edge", dom_clk_en, 6'h3F);
    step(1);
    chk("R5 R1 clock stops first", dom_clk_en, 6'h3D);
    chk("R5 rail still on", dom_rail_en, 6'h3F);
    chk("R5 ready dropped", dom_ready, 6'h3D);
    step(1);
    chk("R5 rail off one cycle later", dom_rail_en, 6'h3D);
  endtask

  task automatic t_power_up();
    logic [7:0] v;
    wr(4'd9, 8'd3);
    wr(4'd10, 8'd0);
    rd(4'd9, v);  chk("R11 cache wake count", v, 3);
    rd(4'd10, v); chk("R6 zero count stored as one", v, 1);
    rd(4'd8, v);  chk("R11 core wake count untouched", v, 4);
    wr(4'd1, 8'h3F);
    chk("R6 rail not yet on", dom_rail_en, 6'h3D);
    step(1);
    chk("R6 rail on first", dom_rail_en, 6'h3F);
    chk("R6 clock held during wake", dom_clk_en, 6'h3D);
    chk("R10 no clock without rail", dom_clk_en & ~dom_rail_en, 0);
    step(2);
    chk("R6 not ready before count", dom_ready, 6'h3D);
    step(1);
    chk("R6 ready after count", dom_ready, 6'h3F);
    chk("R6 clock after count", dom_clk_en, 6'h3F);
    // DMA with count one
    wr(4'd1, 8'h3B);
    step(2);
    chk("R5 dma rail off", dom_rail_en, 6'h3B);
    chk("R10 dma ready off", dom_ready, 6'h3B);
    wr(4'd1, 8'h3F);
    step(1);
    chk("R6 dma rail on", dom_rail_en, 6'h3F);
    chk("R6 dma not ready yet", dom_ready, 6'h3B);
    step(1);
    chk("R6 dma ready after one", dom_ready, 6'h3F);
  endtask

  task automatic t_core_lock();
    logic [7:0] v;
    wr(4'd1, 8'h1E);
    rd(4'd1, v); chk("R7 core bit kept in reg", v, 8'h1F);
    chk("R7 err set", core_rail_err, 1);
    step(2);
    chk("R7 other bits applied, core on", dom_rail_en, 6'h1F);
    wr(4'd3, 8'h00);
    chk("R8 err kept on zero write", core_rail_err, 1);
    rd(4'd3, v); chk("R3 err readback", v, 1);
    wr(4'd3, 8'h01);
    chk("R8 err cleared", core_rail_err, 0);
    wr(4'd1, 8'h3F);
    step(7);
    chk("R6 restore all ready", dom_ready, 6'h3F);
  endtask

  task automatic t_clkgen();
    logic [7:0] v;
    wr(4'd0, 8'h08);
    chk("R9 generator clock held", dom_clk_en, 6'h3F);
    rd(4'd0, v); chk("R9 idle reads written value", v, 8'h08);
    wr(4'd0, 8'h3F);
    chk("R9 generator stops when others stop", dom_clk_en, 6'h00);
    wr(4'd0, 8'h0F);
    chk("R9 generator resumes with others", dom_clk_en, 6'h38);
    wr(4'd0, 8'h00);
    chk("R9 all clocks back", dom_clk_en, 6'h3F);
  endtask

  task automatic t_wake_idle();
    wr(4'd0, 8'h10);
    chk("R4 periph clock idled", dom_clk_en, 6'h2F);
    wr(4'd1, 8'h2F);
    step(2);
    chk("R5 periph rail off", dom_rail_en, 6'h2F);
    wr(4'd1, 8'h3F);
    step(5);
    chk("R12 periph ready", dom_ready, 6'h3F);
    chk("R12 periph clock still stopped", dom_clk_en, 6'h2F);
    wr(4'd0, 8'h00);
    chk("R12 periph clock on after clear", dom_clk_en, 6'h3F);
  endtask

  initial begin
    t_reset_profiles();
    t_idle();
    t_power_down();
    t_power_up();
    t_core_lock();
    t_clkgen();
    t_wake_idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule